// File: doc/BRIEF.md
# Modular Multiplicative Sequence Generator

This block produces a repeating pseudo-random sequence of residues. Term k of the sequence is (k × MULT) mod MODULUS, where MULT and MODULUS are compile-time primes with MULT < MODULUS. It needs no multiplier and no divider. Each new term is the previous term plus MULT, and MODULUS is subtracted once when that sum reaches or passes the modulus. The index k counts from 0 up to MODULUS−1 and then returns to 0. The period is therefore exactly MODULUS steps, and in every period each residue 0 … MODULUS−1 appears once. The defaults are MULT = 7 and MODULUS = 17.

A client steps the sequence by raising the enable and holds it by lowering the enable. A restart pulse returns the sequence to its origin. A one-cycle wrap pulse marks the step from the last index back to 0. This lets downstream logic count whole periods. If the parameters are not both prime, or if MULT is not below MODULUS, elaboration stops with an error.

Top module: `modseq_gen`

## Requirements
- R1: When the synchronous reset (active high) is sampled high at a clock edge, term, index and wrap are all 0 after that edge, whatever the other inputs are.
- R2: At every cycle out of reset, the term output equals (index × MULT) mod MODULUS, and both term and index are below MODULUS.
- R3: At an edge with enable high, restart low and index below MODULUS−1, the index increases by exactly 1 and the term becomes (term + MULT) mod MODULUS.
- R4: At an edge with enable high, restart low and index equal to MODULUS−1, index and term both become 0 and wrap is 1 for exactly the following cycle. Wrap is 0 in every other cycle.
- R5: At an edge with enable low and restart low, term and index keep their values and wrap is 0.
- R6: At an edge with restart high, index and term become 0 whatever the enable is. This takes priority over stepping, and wrap stays 0 even when the index was MODULUS−1.
- R7: Starting from index 0, MODULUS consecutive enabled steps visit every residue 0 … MODULUS−1 exactly once on the term output. The run ends back at index 0, so the period is exactly MODULUS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the sequence by one term at this edge |
| restart_i | input | 1 | Return index and term to 0 at this edge; overrides en_i |
| term_o | output | $clog2(MODULUS) | Current sequence term (index × MULT) mod MODULUS |
| index_o | output | $clog2(MODULUS) | Current index k, 0 … MODULUS−1 |
| wrap_o | output | 1 | One-cycle pulse after the step from index MODULUS−1 to 0 |

## Verification
The bench goes after the wrap boundary in several ways. It holds the enable low while the index sits at MODULUS−1, which must not fire wrap or move the term. It restarts at that same index, which must give 0 with no wrap; a design that let the step path win would pulse wrap there. It walks two full periods and counts each residue. A wrong conditional subtraction, for example a compare with > instead of ≥, would produce the value MODULUS or repeat a residue, and the count catches that. The bench also asserts reset with the enable high in mid-sequence and mixes enable and restart patterns. These catch a hold path that drops the term, or an index and term that drift out of step.

// File: rtl/modseq_pkg.sv
package modseq_pkg;

    // Trial division; used only at elaboration time on parameters.
    function automatic bit is_prime(input int unsigned n);
        bit ok;
        ok = (n >= 2);
        for (int unsigned d = 2; d * d <= n; d++) begin
            if ((n % d) == 0) ok = 1'b0;
        end
        return ok;
    endfunction

    // What the sequencer does at the next edge.
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_STEP    = 2'd1,
        ACT_WRAP    = 2'd2,
        ACT_RESTART = 2'd3
    } seq_act_e;

endpackage

// File: rtl/modseq_residue_step.sv
// Adds the multiplier to a residue and folds the sum back below the modulus
// with a single conditional subtraction (valid because MULT < MODULUS).
module modseq_residue_step #(
    parameter int unsigned MULT    = 7,
    parameter int unsigned MODULUS = 17,
    parameter int unsigned W       = 5
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    localparam logic [W:0] MULT_X = (W+1)'(MULT);
    localparam logic [W:0] MOD_X  = (W+1)'(MODULUS);

    logic [W:0] sum;
    logic [W:0] folded;

    always_comb begin
        sum    = {1'b0, cur_i} + MULT_X;
        folded = (sum >= MOD_X) ? (sum - MOD_X) : sum;
        nxt_o  = folded[W-1:0];
    end
endmodule

// File: rtl/modseq_index_ctr.sv
// Index increment plus detection of the last index of a period.
module modseq_index_ctr #(
    parameter int unsigned MODULUS = 17,
    parameter int unsigned W       = 5
) (
    input  logic [W-1:0] idx_i,
    output logic [W-1:0] idx_inc_o,
    output logic         is_last_o
);
    localparam logic [W-1:0] LAST_IDX = W'(MODULUS - 1);

    always_comb begin
        idx_inc_o = idx_i + W'(1);
        is_last_o = (idx_i == LAST_IDX);
    end
endmodule

// File: rtl/modseq_gen.sv
module modseq_gen
    import modseq_pkg::*;
#(
    parameter int unsigned MULT    = 7,
    parameter int unsigned MODULUS = 17
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       en_i,
    input  logic                       restart_i,
    output logic [$clog2(MODULUS)-1:0] term_o,
    output logic [$clog2(MODULUS)-1:0] index_o,
    output logic                       wrap_o
);
    localparam int unsigned W = $clog2(MODULUS);

    generate
        if (!is_prime(MULT) || !is_prime(MODULUS) || (MULT >= MODULUS)) begin : g_param_bad
            $error("modseq_gen: MULT and MODULUS must be prime with MULT < MODULUS");
        end
    endgenerate

    typedef struct packed {
        logic [W-1:0] term;
        logic [W-1:0] idx;
        logic         wrap;
    } seq_state_t;

    seq_state_t state_d, state_q;
    seq_act_e   act_d;

    logic [W-1:0] term_step;
    logic [W-1:0] idx_inc;
    logic         idx_last;

    modseq_residue_step #(
        .MULT    (MULT),
        .MODULUS (MODULUS),
        .W       (W)
    ) u_step (
        .cur_i (state_q.term),
        .nxt_o (term_step)
    );

    modseq_index_ctr #(
        .MODULUS (MODULUS),
        .W       (W)
    ) u_idx (
        .idx_i     (state_q.idx),
        .idx_inc_o (idx_inc),
        .is_last_o (idx_last)
    );

    // Next-state process
    always_comb begin
        if (restart_i)      act_d = ACT_RESTART;
        else if (!en_i)     act_d = ACT_HOLD;
        else if (idx_last)  act_d = ACT_WRAP;
        else                act_d = ACT_STEP;

        state_d      = state_q;
        state_d.wrap = 1'b0;
        unique case (act_d)
            ACT_RESTART: begin
                state_d.term = '0;
                state_d.idx  = '0;
            end
            ACT_WRAP: begin
                state_d.term = '0;
                state_d.idx  = '0;
                state_d.wrap = 1'b1;
            end
            ACT_STEP: begin
                state_d.term = term_step;
                state_d.idx  = idx_inc;
            end
            default: ;
        endcase
    end

    // Register process
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    assign term_o  = state_q.term;
    assign index_o = state_q.idx;
    assign wrap_o  = state_q.wrap;

endmodule

// File: rtl/modseq_gen_sva.sv
module modseq_gen_sva #(
    parameter int unsigned MULT    = 7,
    parameter int unsigned MODULUS = 17,
    parameter int unsigned W       = 5
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         en_i,
    input logic         restart_i,
    input logic [W-1:0] term_o,
    input logic [W-1:0] index_o,
    input logic         wrap_o
);
    localparam logic [W-1:0] LAST_IDX = W'(MODULUS - 1);

    // R1: reset clears everything at the next edge
    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (term_o == '0 && index_o == '0 && !wrap_o));

    // R2: term tracks index*MULT mod MODULUS
    p_term_matches_index_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ({{(32-W){1'b0}}, term_o} == ((32'(index_o) * 32'(MULT)) % 32'(MODULUS))));

    // R2: both outputs stay below the modulus
    p_in_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (32'(term_o) < 32'(MODULUS)) && (32'(index_o) < 32'(MODULUS)));

    // R3: ordinary step advances the index by one
    p_index_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !restart_i && index_o != LAST_IDX) |=> (index_o == $past(index_o) + W'(1)));

    // R4: wrap step lands on zero with a pulse
    p_wrap_landing_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !restart_i && index_o == LAST_IDX) |=> (wrap_o && index_o == '0 && term_o == '0));

    // R4: wrap never lasts two cycles
    p_wrap_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> !wrap_o);

    // R5: hold keeps state and no pulse
    p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !restart_i) |=> ($stable(term_o) && $stable(index_o) && !wrap_o));

    // R6: restart wins, without a wrap pulse
    p_restart_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_i |=> (term_o == '0 && index_o == '0 && !wrap_o));

endmodule

bind modseq_gen modseq_gen_sva #(
    .MULT    (MULT),
    .MODULUS (MODULUS),
    .W       (W)
) u_sva (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_i),
    .restart_i (restart_i),
    .term_o    (term_o),
    .index_o   (index_o),
    .wrap_o    (wrap_o)
);

// File: tb/modseq_gen_tb_top.sv
`timescale 1ns/1ps
module modseq_gen_tb_top;
    localparam int unsigned MULT    = 7;
    localparam int unsigned MODULUS = 17;
    localparam int unsigned W       = $clog2(MODULUS);
    localparam int          NSTIM   = 24;

    // {en, restart} stimulus table
    localparam logic [1:0] STIM [NSTIM] = '{
        2'b10, 2'b10, 2'b10, 2'b00, 2'b00, 2'b10, 2'b11, 2'b10,
        2'b10, 2'b01, 2'b10, 2'b00, 2'b10, 2'b10, 2'b10, 2'b11,
        2'b00, 2'b10, 2'b10, 2'b10, 2'b10, 2'b00, 2'b01, 2'b10
    };

    logic         clk = 1'b0;
    logic         rst_i = 1'b1;
    logic         en_i = 1'b0;
    logic         restart_i = 1'b0;
    logic [W-1:0] term_o;
    logic [W-1:0] index_o;
    logic         wrap_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int unsigned m_k = 0;
    bit          m_wrap = 1'b0;

    always #2.5 clk = ~clk;

    modseq_gen #(.MULT(MULT), .MODULUS(MODULUS)) dut_i (
        .clk_i     (clk),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .restart_i (restart_i),
        .term_o    (term_o),
        .index_o   (index_o),
        .wrap_o    (wrap_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, "index", int'(index_o), int'(m_k));
        check(req, "term",  int'(term_o),  int'((m_k * MULT) % MODULUS));
        check(req, "wrap",  int'(wrap_o),  int'(m_wrap));
    endtask

    // Drive inputs, take one edge, update the reference, compare.
    task automatic cyc(input bit rs, input bit en, input bit rst_n_hold);
        rst_i     = rs;
        en_i      = en;
        restart_i = rst_n_hold;
        @(posedge clk);
        #1;
        if (rs || rst_n_hold) begin
            m_k = 0; m_wrap = 1'b0;
        end else if (en) begin
            if (m_k == MODULUS - 1) begin m_k = 0; m_wrap = 1'b1; end
            else begin m_k = m_k + 1; m_wrap = 1'b0; end
        end else begin
            m_wrap = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        int unsigned seen [MODULUS];
        // R1: reset state
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        check_outputs("R1");

        // Table walk: R2 R3 R5 R6 under mixed patterns
        for (int i = 0; i < NSTIM; i++) begin
            cyc(1'b0, STIM[i][1], STIM[i][0]);
            check_outputs(STIM[i][0] ? "R6" : (STIM[i][1] ? "R3" : "R5"));
        end

        // Two full periods from zero, counting residues: R7 R4 R2
        cyc(1'b0, 1'b0, 1'b1);
        check_outputs("R6");
        for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < MODULUS; r++) seen[r] = 0;
            for (int s = 0; s < MODULUS; s++) begin
                seen[term_o] = seen[term_o] + 1;
                cyc(1'b0, 1'b1, 1'b0);
                check_outputs("R2");
            end
            for (int r = 0; r < MODULUS; r++) check("R7", "residue_count", int'(seen[r]), 1);
            check("R7", "index_after_period", int'(index_o), 0);
            check("R4", "wrap_at_period_end", int'(wrap_o), 1);
        end

        // Hold at the last index: R5, then wrap pulse: R4
        while (m_k != MODULUS - 1) cyc(1'b0, 1'b1, 1'b0);
        check_outputs("R3");
        for (int h = 0; h < 3; h++) begin
            cyc(1'b0, 1'b0, 1'b0);
            check_outputs("R5");
        end
        cyc(1'b0, 1'b1, 1'b0);
        check_outputs("R4");
        check("R4", "wrap_pulse", int'(wrap_o), 1);
        cyc(1'b0, 1'b0, 1'b0);
        check_outputs("R4");
        check("R4", "wrap_drops", int'(wrap_o), 0);

        // Restart at last index with enable high: R6
        while (m_k != MODULUS - 1) cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b1);
        check_outputs("R6");
        check("R6", "no_wrap_on_restart", int'(wrap_o), 0);

        // Reset mid-sequence with enable high: R1
        for (int s = 0; s < 5; s++) cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        check_outputs("R1");
        check("R1", "index_after_reset", int'(index_o), 0);
        cyc(1'b0, 1'b1, 1'b0);
        check_outputs("R3");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end
endmodule